// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card clock from the host clock under the control of two small registers. The divider control register carries a card-clock enable and an eight-bit one-hot divide select. The gate register carries a second enable. The card clock runs only when both enables are set. It ranges from the host clock divided by 512 down to divide-by-2. The divide-by-2 setting also raises a bypass request, which tells neighbouring logic to switch the pad to the undivided host clock.

Software stops the clock by clearing the gate register first and the divider enable second. It starts the clock in the reverse order: divider enable first, gate register next. Any change to the select or to either enable takes effect only while the card clock is low. A high phase that has begun always runs to its full length, so no runt pulse reaches the card. Besides the clock level, the block gives a one-cycle strobe in the first host cycle of every card-clock high phase. Logic that runs on the host clock uses it as a clock enable.

Top module: `sdclk_divider`

## Requirements
- R1: After reset both registers read zero, the card clock is low, and the strobe and the bypass request are low.
- R2: Register address 0 is the divider control register. Bits 8:0 are stored on a write. Bit 8 is the divider enable, bits 7:0 are the divide select, and bits 15:9 always read zero.
- R3: Register address 1 is the gate register. Only bit 8 (the gate enable) is stored; every other bit reads zero.
- R4: With exactly bit k (0 to 7) of the select set and the clock running, the card clock period is 4·2^k host cycles, with 2·2^k cycles high.
- R5: When several select bits are set, the highest set bit (the slowest rate) decides the period.
- R6: With the select at zero and the clock running, the card clock toggles every host cycle (period 2) and the bypass request is high. The bypass request is low for any nonzero select and whenever the clock is stopped.
- R7: The card clock toggles only while both the divider enable and the gate enable are set. With either one clear, it stays low.
- R8: A select written while the card clock is high leaves that high phase at its old length. The new rate applies from the following low phase onward.
- R9: Clearing either enable during a high phase lets the phase finish at full length. The clock then stays low.
- R10: The strobe is high for exactly one host cycle per card-clock period: the first cycle of each high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 1 | Write target: 0 divider control, 1 gate |
| wr_data | input | 16 | Write data |
| rd_addr | input | 1 | Read target: 0 divider control, 1 gate |
| rd_data | output | 16 | Read data (combinational) |
| card_clk_o | output | 1 | Divided card clock level |
| card_stb_o | output | 1 | One-cycle pulse at each card clock rising edge |
| bypass_o | output | 1 | Request to drive the card from the undivided host clock |

## Verification
The hardest situation to reach is a register write that lands inside a card-clock high phase. The write must then be held off, so the high phase keeps its old length. The bench waits for a rising edge of the card clock at the slowest rate and writes a fast select a cycle later. It counts the remaining high cycles, and it repeats the same pattern with a stop write in place of the select change. A sweep over every single select bit, over multi-bit selects and over the zero select checks the period, the high time and the strobe count, against values the bench computes from the bit position.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int CTRL_W = 16;
  localparam int SEL_W  = 8;
  localparam int EN_BIT = 8;
  localparam int HALF_W = SEL_W + 1;

  // Half period in host cycles: highest set select bit k gives 2<<k; zero gives 1.
  function automatic logic [HALF_W-1:0] half_period(input logic [SEL_W-1:0] sel);
    logic [HALF_W-1:0] h;
    h = 1;
    for (int k = 0; k < SEL_W; k++) begin
      if (sel[k]) h = HALF_W'(2) << k;
    end
    return h;
  endfunction
endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
  import sdclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [CTRL_W-1:0] rd_data,
  output logic [SEL_W-1:0]  sel_o,
  output logic              run_o
);
  logic [EN_BIT:0] ctrl_q;
  logic            gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      gate_q <= 1'b0;
    end else if (wr_en) begin
      if (!wr_addr) ctrl_q <= wr_data[EN_BIT:0];
      else          gate_q <= wr_data[EN_BIT];
    end
  end

  always_comb begin
    rd_data = '0;
    if (!rd_addr) rd_data[EN_BIT:0] = ctrl_q;
    else          rd_data[EN_BIT]   = gate_q;
  end

  assign sel_o = ctrl_q[SEL_W-1:0];
  assign run_o = ctrl_q[EN_BIT] & gate_q;

  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr) |=> (ctrl_q == $past(wr_data[EN_BIT:0])));
  p_gate_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr) |=> $stable(gate_q));
endmodule

// File: rtl/sdclk_decode.sv
module sdclk_decode
  import sdclk_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  output logic [HALF_W-1:0] half_o
);
  assign half_o = half_period(sel_i);

  always_comb begin
    assert (half_o != '0);
  end
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_run,
  input  logic [HALF_W-1:0] req_half,
  output logic              card_clk_o,
  output logic              card_stb_o,
  output logic              bypass_o
);
  logic              clk_q, stb_q, act_run;
  logic [HALF_W-1:0] cnt, act_half;
  logic [HALF_W-1:0] eff_half;
  logic              phase_end, rise_evt;

  // Settings follow the request only while the card clock is low.
  assign eff_half  = clk_q ? act_half : req_half;
  assign phase_end = (cnt >= eff_half - 1'b1);
  assign rise_evt  = !clk_q && req_run && phase_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q    <= 1'b0;
      stb_q    <= 1'b0;
      cnt      <= '0;
      act_run  <= 1'b0;
      act_half <= HALF_W'(1);
    end else begin
      if (!clk_q) begin
        act_run  <= req_run;
        act_half <= req_half;
      end
      stb_q <= rise_evt;
      if (!clk_q && !req_run) begin
        cnt <= '0;
      end else if (phase_end) begin
        cnt   <= '0;
        clk_q <= ~clk_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign card_clk_o = clk_q;
  assign card_stb_o = stb_q;
  assign bypass_o   = act_run && (act_half == HALF_W'(1));

  p_hold_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_q && $past(clk_q)) |-> $stable(act_half));
  p_stop_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_q && !req_run) |=> !clk_q);
  p_stb_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_q) |-> stb_q);
  p_stb_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> clk_q);
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_q |-> (cnt < act_half));
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [CTRL_W-1:0] rd_data,
  output logic              card_clk_o,
  output logic              card_stb_o,
  output logic              bypass_o
);
  logic [SEL_W-1:0]  sel_w;
  logic              run_w;
  logic [HALF_W-1:0] half_w;

  sdclk_regs i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sel_o(sel_w), .run_o(run_w)
  );

  sdclk_decode i_decode (.sel_i(sel_w), .half_o(half_w));

  sdclk_gen i_gen (
    .clk(clk), .rst_n(rst_n), .req_run(run_w), .req_half(half_w),
    .card_clk_o(card_clk_o), .card_stb_o(card_stb_o), .bypass_o(bypass_o)
  );

  p_bypass_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_o && !card_clk_o) |-> (run_w || $past(run_w)));
endmodule

// File: tb/test_sdclk_divider.sv
module test_sdclk_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [15:0] rd_data;
  logic        card_clk_o, card_stb_o, bypass_o;
  int          n_chk = 0;
  int          n_err = 0;
  int          cyc = 0;

  always #2.5 clk = ~clk;

  sdclk_divider i_sdclk_divider (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .card_clk_o(card_clk_o), .card_stb_o(card_stb_o), .bypass_o(bypass_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_err = n_err + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output int v);
    rd_addr = a;
    #0.1;
    v = rd_data;
  endtask

  // Wait for the first high sample of the card clock.
  task automatic wait_rise(output int ok);
    int n = 0;
    while (card_clk_o && n < 5000) begin @(negedge clk); n++; end
    while (!card_clk_o && n < 5000) begin @(negedge clk); n++; end
    ok = (n < 5000);
  endtask

  // Measure one full period starting at a rising edge.
  task automatic measure(output int hi, output int per, output int stbs);
    int ok;
    wait_rise(ok);
    hi = 0; per = 0; stbs = 0;
    if (!ok) return;
    while (card_clk_o && hi < 2000) begin
      if (card_stb_o) stbs++;
      hi++; per++; @(negedge clk);
    end
    while (!card_clk_o && per < 4000) begin
      if (card_stb_o) stbs++;
      per++; @(negedge clk);
    end
  endtask

  initial begin
    int v, hi, per, stbs, ok, lows;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(1'b0, v); chk("R1 ctrl reads zero", v, 0);
    rd(1'b1, v); chk("R1 gate reads zero", v, 0);
    chk("R1 card clock low", card_clk_o, 0);
    chk("R1 strobe low", card_stb_o, 0);
    chk("R1 bypass low", bypass_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3 register decode
    wr(1'b0, 16'hFFFF); rd(1'b0, v); chk("R2 ctrl keeps 8:0 only", v, 16'h01FF);
    wr(1'b1, 16'hFFFF); rd(1'b1, v); chk("R3 gate keeps bit 8 only", v, 16'h0100);
    wr(1'b0, 16'h0000); rd(1'b1, v); chk("R3 gate untouched by ctrl write", v, 16'h0100);
    wr(1'b1, 16'h0000); rd(1'b0, v); chk("R2 ctrl after clear", v, 0);

    // R7 start order: divider enable alone keeps the clock low
    wr(1'b0, 16'h0101);
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      if (!card_clk_o) lows++;
      @(negedge clk);
    end
    chk("R7 divider enable alone: clock low", lows, 40);
    wr(1'b1, 16'h0100);

    // R4 sweep over every single select bit
    for (int k = 0; k < 8; k++) begin
      wr(1'b0, 16'h0100 | (16'h1 << k));
      measure(hi, per, stbs);
      chk($sformatf("R4 period bit%0d", k), per, 4 << k);
      chk($sformatf("R4 high bit%0d", k), hi, 2 << k);
      chk($sformatf("R10 strobes bit%0d", k), stbs, 1);
      chk($sformatf("R6 bypass low bit%0d", k), bypass_o, 0);
    end

    // R5 multi-bit selects: highest set bit wins
    wr(1'b0, 16'h0105); measure(hi, per, stbs); chk("R5 sel 0x05 period", per, 16);
    wr(1'b0, 16'h010E); measure(hi, per, stbs); chk("R5 sel 0x0E period", per, 32);
    wr(1'b0, 16'h01FF); measure(hi, per, stbs); chk("R5 sel 0xFF period", per, 512);

    // R6 zero select: period 2 and bypass
    wr(1'b0, 16'h0100);
    measure(hi, per, stbs);
    chk("R6 zero select period", per, 2);
    chk("R10 zero select strobes", stbs, 1);
    repeat (3) @(negedge clk);
    chk("R6 bypass high", bypass_o, 1);

    // R8 select change inside a slow high phase
    wr(1'b0, 16'h0180);
    wait_rise(ok);
    wait_rise(ok);
    wr(1'b0, 16'h0101);
    hi = 1;
    while (card_clk_o && hi < 2000) begin hi++; @(negedge clk); end
    chk("R8 high phase keeps old length", hi, 256);
    measure(hi, per, stbs);
    chk("R8 new rate after low phase", per, 4);

    // R9 stop through the gate register during a high phase
    wr(1'b0, 16'h0104);
    wait_rise(ok);
    wait_rise(ok);
    wr(1'b1, 16'h0000);
    hi = 1;
    while (card_clk_o && hi < 2000) begin hi++; @(negedge clk); end
    chk("R9 gate stop keeps full high", hi, 8);
    lows = 0; stbs = 0;
    for (int i = 0; i < 60; i++) begin
      if (!card_clk_o) lows++;
      if (card_stb_o) stbs++;
      @(negedge clk);
    end
    chk("R9 stays low after gate stop", lows, 60);
    chk("R10 no strobe while stopped", stbs, 0);
    chk("R6 bypass low while stopped", bypass_o, 0);

    // R9 stop through the divider enable during a high phase
    wr(1'b1, 16'h0100);
    wait_rise(ok);
    wr(1'b0, 16'h0004);
    hi = 1;
    while (card_clk_o && hi < 2000) begin hi++; @(negedge clk); end
    chk("R9 enable stop keeps full high", hi, 8);
    lows = 0;
    for (int i = 0; i < 60; i++) begin
      if (!card_clk_o) lows++;
      @(negedge clk);
    end
    chk("R7 gate alone: clock low", lows, 60);

    // R6 stopped zero select: no bypass
    wr(1'b0, 16'h0000);
    repeat (4) @(negedge clk);
    chk("R6 bypass low with zero field disabled", bypass_o, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule